// File: doc/BRIEF.md
# Stop-State Wake-Up Sequencer

This block brings a processor core out of its low-power stop state. While the core runs, a stop request turns off the core clock enable. An active-low external interrupt line then wakes the block. A low level on that line starts the clock generator again and loads a wake-up delay counter. The delay length comes from a mode input: a long delay lets an on-chip oscillator settle, and a short delay suits a clock that is already stable. The core clock stays gated for the whole delay.

The block ignores the interrupt line for most of the delay. A two-flop synchronizer turns on only for the final few counts. The level it captures there decides whether the wake-up interrupt counts as pending, so a line released early leaves no pending flag. After the delay comes a fixed tail of stop cycles with the clock enabled. Arbitration happens in the first tail cycle, between the wake-up interrupt and the other pending interrupt requests. At the end of the tail, one decision cycle tells the core either to take the winning interrupt (with its vector index) or to resume at the instruction after the stop.

States: `ST_RUN` (core running), `ST_HALT` (stopped, waiting for the line), `ST_DELAY` (counting the wake-up delay), `ST_TAIL` (fixed stop cycles, arbitration in the first one) and `ST_DECIDE` (one-cycle decision). Transitions: RUN→HALT on a stop request; HALT→DELAY on a low interrupt line; DELAY→TAIL when the count reaches zero; TAIL→DECIDE after the last tail cycle; DECIDE→RUN always.

Top module: `stop_wake_seq`

## Requirements
- R1: After reset the block is running: `core_clk_en`=1, `irqa_pending`=0, `resume_next`=0, `take_irq`=0.
- R2: A `stop_req` sampled high while running drops `core_clk_en` to 0 from the next cycle. It stays 0 for as long as `irqa_n` stays high.
- R3: While stopped, a low `irqa_n` at a clock edge starts the delay in the next cycle. `fast_wake` is sampled at that same edge. `core_clk_en` stays 0 for every delay cycle.
- R4: With `fast_wake`=0 the delay lasts LONG_DELAY cycles (default 131072).
- R5: With `fast_wake`=1 the delay lasts SHORT_DELAY cycles (default 16).
- R6: The wake-up interrupt is pending only if `irqa_n` is low at the edge that ends the second-to-last delay cycle. Levels earlier in the delay have no effect.
- R7: After the delay, `core_clk_en`=1 for TAIL_LEN tail cycles (default 17). Then one decision cycle follows, and after it the block is running again.
- R8: In the decision cycle, `take_irq`=1 if any request is pending, and `vec_sel` is the lowest pending index. The wake-up interrupt is index 0 and `other_irq[i]` is index i+1. `other_irq` is sampled at the end of the first tail cycle. With nothing pending, `resume_next`=1 instead. The two never assert together.
- R9: `stop_req` has no effect outside the running state, and `fast_wake` has no effect after the delay has started.
- R10: `irqa_pending` shows the wake-up interrupt flag from the second tail cycle on. It holds until the next stop entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| rst_n | input | 1 | Active-low reset |
| stop_req | input | 1 | Core asks to enter stop state |
| irqa_n | input | 1 | Active-low external wake-up interrupt line |
| fast_wake | input | 1 | 1 selects short delay, 0 the long one |
| other_irq | input | N_OTHER | Other pending interrupt requests |
| core_clk_en | output | 1 | Core clock enable |
| irqa_pending | output | 1 | Wake-up interrupt recorded as pending |
| resume_next | output | 1 | Decision cycle: resume after the stop |
| take_irq | output | 1 | Decision cycle: service an interrupt |
| vec_sel | output | $clog2(N_OTHER+1) | Index of the winning interrupt |

## Verification
The hardest case to reach is a release of the interrupt line that lands right on the synchronizer window. One cycle earlier or later flips the pending decision. The bench therefore sweeps the release cycle over every position in the delay, for both delay lengths, in a shortened configuration. It varies the other requests with each run and drives stray stop requests and mode flips mid-delay. This checks both the exact boundary and that nothing else leaks into the decision.

// File: rtl/swk_pkg.sv
package swk_pkg;
    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_HALT   = 3'd1,
        ST_DELAY  = 3'd2,
        ST_TAIL   = 3'd3,
        ST_DECIDE = 3'd4
    } wake_state_e;
endpackage

// File: rtl/wake_cnt.sv
module wake_cnt #(
    parameter int LONG_DELAY  = 131072,
    parameter int SHORT_DELAY = 16,
    parameter int SYNC_WINDOW = 4,
    parameter int CNT_W       = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic sel_short,
    input  logic run,
    output logic done,
    output logic in_win
);
    localparam logic [CNT_W-1:0] LOAD_LONG  = CNT_W'(LONG_DELAY - 1);
    localparam logic [CNT_W-1:0] LOAD_SHORT = CNT_W'(SHORT_DELAY - 1);
    localparam logic [CNT_W-1:0] WIN_LIM    = CNT_W'(SYNC_WINDOW);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= sel_short ? LOAD_SHORT : LOAD_LONG;
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done   = (cnt_q == '0);
    assign in_win = (cnt_q < WIN_LIM);

    // R4, R5: counter steps down by one each delay cycle
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && !done) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/irq_level_sync.sv
module irq_level_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic irq_n,
    output logic irq_act
);
    logic s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else if (clr) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else if (en) begin
            s1_q <= irq_n;
            s2_q <= s1_q;
        end
    end

    assign irq_act = !s2_q;

    // R6: outside the window the line is not sampled
    assert_sync_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable({s1_q, s2_q}));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N_REQ = 4,
    parameter int IDX_W = 2
) (
    input  logic [N_REQ-1:0] req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N_REQ - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
        any = |req;
    end

    // R8: winner is a set request with nothing of lower index set
    always_comb begin
        if (any) begin
            assert_winner_lowest_R8: assert (req[idx] &&
                ((req & ((N_REQ'(1) << idx) - N_REQ'(1))) == '0));
        end
    end
endmodule

// File: rtl/stop_wake_seq.sv
module stop_wake_seq
    import swk_pkg::*;
#(
    parameter int LONG_DELAY  = 131072,
    parameter int SHORT_DELAY = 16,
    parameter int SYNC_WINDOW = 4,
    parameter int TAIL_LEN    = 17,
    parameter int N_OTHER     = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               stop_req,
    input  logic                               irqa_n,
    input  logic                               fast_wake,
    input  logic [N_OTHER-1:0]                 other_irq,
    output logic                               core_clk_en,
    output logic                               irqa_pending,
    output logic                               resume_next,
    output logic                               take_irq,
    output logic [$clog2(N_OTHER+1)-1:0]       vec_sel
);
    localparam int MAXD   = (LONG_DELAY > SHORT_DELAY) ? LONG_DELAY : SHORT_DELAY;
    localparam int CNT_W  = (MAXD > 2) ? $clog2(MAXD) : 1;
    localparam int N_REQ  = N_OTHER + 1;
    localparam int VEC_W  = $clog2(N_REQ);
    localparam int TAIL_W = (TAIL_LEN > 2) ? $clog2(TAIL_LEN) : 1;
    localparam logic [TAIL_W-1:0] TAIL_LAST = TAIL_W'(TAIL_LEN - 1);

    wake_state_e state_q, state_d;
    logic [TAIL_W-1:0] tail_q;
    logic              pend_q, any_q;
    logic [VEC_W-1:0]  vec_q;

    logic cnt_done, cnt_win, irqa_act, pick_any;
    logic [VEC_W-1:0] pick_idx;
    logic stop_entry, wake_start, arb_cycle, tail_last;

    assign stop_entry = (state_q == ST_RUN) && stop_req;
    assign wake_start = (state_q == ST_HALT) && !irqa_n;
    assign arb_cycle  = (state_q == ST_TAIL) && (tail_q == '0);
    assign tail_last  = (tail_q == TAIL_LAST);

    wake_cnt #(
        .LONG_DELAY (LONG_DELAY),
        .SHORT_DELAY(SHORT_DELAY),
        .SYNC_WINDOW(SYNC_WINDOW),
        .CNT_W      (CNT_W)
    ) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wake_start),
        .sel_short(fast_wake),
        .run      (state_q == ST_DELAY),
        .done     (cnt_done),
        .in_win   (cnt_win)
    );

    irq_level_sync i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (state_q == ST_HALT),
        .en     ((state_q == ST_DELAY) && cnt_win),
        .irq_n  (irqa_n),
        .irq_act(irqa_act)
    );

    irq_prio_pick #(.N_REQ(N_REQ), .IDX_W(VEC_W)) i_pick (
        .req({other_irq, irqa_act}),
        .any(pick_any),
        .idx(pick_idx)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (stop_req)  state_d = ST_HALT;
            ST_HALT:   if (!irqa_n)   state_d = ST_DELAY;
            ST_DELAY:  if (cnt_done)  state_d = ST_TAIL;
            ST_TAIL:   if (tail_last) state_d = ST_DECIDE;
            ST_DECIDE:                state_d = ST_RUN;
            default:                  state_d = ST_RUN;
        endcase
    end

    // state register and sequencing state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            tail_q  <= '0;
            pend_q  <= 1'b0;
            any_q   <= 1'b0;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            tail_q  <= (state_q == ST_TAIL) ? tail_q + 1'b1 : '0;
            if (stop_entry) begin
                pend_q <= 1'b0;
                any_q  <= 1'b0;
                vec_q  <= '0;
            end else if (arb_cycle) begin
                pend_q <= irqa_act;
                any_q  <= pick_any;
                vec_q  <= pick_idx;
            end
        end
    end

    // outputs
    always_comb begin
        core_clk_en = 1'b1;
        resume_next = 1'b0;
        take_irq    = 1'b0;
        unique case (state_q)
            ST_RUN, ST_TAIL: core_clk_en = 1'b1;
            ST_HALT, ST_DELAY: core_clk_en = 1'b0;
            ST_DECIDE: begin
                take_irq    = any_q;
                resume_next = !any_q;
            end
            default: core_clk_en = 1'b1;
        endcase
        irqa_pending = pend_q;
        vec_sel      = vec_q;
    end

    assert_stop_gates_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_entry |=> !core_clk_en);
    assert_delay_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DELAY) && cnt_done) |=> (core_clk_en && state_q == ST_TAIL));
    assert_decide_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_next || take_irq) |=> (!resume_next && !take_irq && core_clk_en));
    assert_stop_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DELAY) && !cnt_done) |=> (state_q == ST_DELAY));
    assert_pend_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_entry && !arb_cycle) |=> $stable(irqa_pending));
endmodule

// File: tb/test_stop_wake_seq.sv
module test_stop_wake_seq;
    localparam int LD = 40;
    localparam int SD = 16;
    localparam int TL = 17;
    localparam int NO = 3;
    localparam int VW = $clog2(NO + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic stop_req = 1'b0, irqa_n = 1'b1, fast_wake = 1'b0;
    logic [NO-1:0] other_irq = '0;
    logic core_clk_en, irqa_pending, resume_next, take_irq;
    logic [VW-1:0] vec_sel;
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    stop_wake_seq #(.LONG_DELAY(LD), .SHORT_DELAY(SD), .SYNC_WINDOW(4),
                    .TAIL_LEN(TL), .N_OTHER(NO)) i_stop_wake_seq (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .irqa_n(irqa_n),
        .fast_wake(fast_wake), .other_irq(other_irq), .core_clk_en(core_clk_en),
        .irqa_pending(irqa_pending), .resume_next(resume_next),
        .take_irq(take_irq), .vec_sel(vec_sel));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_wake(input bit mode, input int j, input logic [NO-1:0] oth,
                            input bit poke);
        int d = mode ? SD : LD;
        int gate_bad = 0, tail_bad = 0;
        bit exp_pend = (j >= d - 1);
        logic [NO:0] req = {oth, exp_pend};
        int exp_vec = 0;
        for (int i = NO; i >= 0; i--) if (req[i]) exp_vec = i;
        other_irq = oth; fast_wake = mode; stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        chk(core_clk_en == 1'b0, "R2 gated after stop", core_clk_en, 0);
        repeat (2) @(negedge clk);
        chk(core_clk_en == 1'b0, "R2 stays gated", core_clk_en, 0);
        irqa_n = 1'b0;
        @(negedge clk);
        for (int k = 0; k < d; k++) begin
            if (core_clk_en !== 1'b0) gate_bad++;
            if (k == j) irqa_n = 1'b1;
            if (poke) begin
                stop_req  = (k == 1);
                if (k == 2) fast_wake = ~mode;
            end
            @(negedge clk);
        end
        stop_req = 1'b0; fast_wake = mode;
        chk(gate_bad == 0, mode ? "R5 R3 short delay gated" : "R4 R3 long delay gated",
            gate_bad, 0);
        for (int t = 0; t < TL; t++) begin
            if (core_clk_en !== 1'b1 || take_irq || resume_next) tail_bad++;
            @(negedge clk);
        end
        chk(tail_bad == 0, poke ? "R7 R9 tail length" : "R7 tail length", tail_bad, 0);
        chk(irqa_pending == exp_pend, "R6 R10 pending flag", irqa_pending, exp_pend);
        chk(take_irq == (req != 0) && resume_next == (req == 0), "R8 decision",
            {take_irq, resume_next}, {(req != 0), (req == 0)});
        if (req != 0) chk(vec_sel == exp_vec, "R8 vector", vec_sel, exp_vec);
        irqa_n = 1'b1;
        @(negedge clk);
        chk(core_clk_en && !take_irq && !resume_next, "R7 back to run",
            core_clk_en, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(core_clk_en && !irqa_pending && !resume_next && !take_irq, "R1 reset state",
            {core_clk_en, irqa_pending, resume_next, take_irq}, 4'b1000);
        for (int m = 0; m < 2; m++) begin
            for (int j = 0; j <= (m ? SD : LD); j++) begin
                run_wake(m[0], j, NO'(j % (1 << NO)), j[0]);
            end
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule